// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Counter

This block is a binary counter built from identical narrow counter stages that share one clock. Every stage holds a small binary count and can be cleared, loaded from a preset word, advanced by one or held. Two count enables decide whether the chain advances. The first enable, `en_p`, only gates counting. The second, `en_t`, also gates the terminal-count carry that passes from stage to stage.

A higher stage advances only when all lower stages sit at their maximum. The moduli of the stages therefore multiply, and the default of two 4-bit stages forms a divide-by-256 counter. The carry out of the top stage is fed back to the shared synchronous load. After reaching the all-ones value, the counter reloads the preset word, which removes counts from the low end of the sequence. A preset of 246 gives a ten-state loop. A preset of 0 gives the full 256-state wrap.

A parameter selects how the stage enables are formed: as a ripple through each stage's carry, or in parallel from the lower stages' full flags.

Top module: `casc_counter`

## Requirements
- R1: When `clr` is high at a rising clock edge, `count` becomes 0 after that edge, regardless of every other input, including a terminal-count reload in the same cycle.
- R2: The load is synchronous. While `ripple_out` is high and `clr` is low, `count` keeps its value until the next rising edge and then takes the value of `preset`. At any other time, a change of `preset` has no effect on `count`.
- R3: With `clr` low, no reload, and both `en_p` and `en_t` high, `count` increases by exactly 1 at each rising edge.
- R4: With `clr` low and no reload, `count` holds its value whenever `en_p` or `en_t` is low.
- R5: `ripple_out` is high exactly when `count` is all ones and `en_t` is high. `en_p` has no influence on `ripple_out`.
- R6: The upper stage changes only when the lower 4-bit stage is at 15 and counting is enabled. Counting from x…1111 carries into the upper stage on the same edge.
- R7: With `preset` = 246 and both enables high, the count visits 246 through 255 in order and then returns to 246, a loop of 10 states.
- R8: With `preset` = 0 and both enables high, the count wraps with a period of 256 cycles, and `ripple_out` is high on exactly one cycle of each period.
- R9: A reload at terminal count takes place even when `en_p` is low, because the load outranks the count enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock, rising edge active |
| clr | input | 1 | Synchronous active-high clear |
| en_p | input | 1 | Count enable that gates counting only |
| en_t | input | 1 | Count enable that gates counting and the carry |
| preset | input | 8 | Value loaded on a terminal-count reload |
| count | output | 8 | Combined count of all stages, lower stage in bits 3:0 |
| ripple_out | output | 1 | Terminal count of the full chain, also the internal reload |

## Verification
Two pairs of operations can fall in the same cycle. The clear can coincide with a terminal-count reload. The reload can coincide with a held count enable. The bench drives the counter to 255 with `en_t` high and then raises `clr` on that same cycle, expecting 0 rather than the preset. A second case holds `en_p` low at 255 and expects the preset rather than a held count. A behavioural model, updated every edge with the stated priority, judges every cycle of both cases alongside the normal counting.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_COUNT = 2'd1,
      OP_LOAD  = 2'd2,
      OP_CLEAR = 2'd3
   } stage_op_e;
endpackage

// File: rtl/cnt_op_sel.sv
module cnt_op_sel
   import cnt_pkg::*;
(
   input  logic      clr,
   input  logic      load,
   input  logic      ent,
   input  logic      enp,
   output stage_op_e op
);
   always_comb begin
      if (clr)
         op = OP_CLEAR;
      else if (load)
         op = OP_LOAD;
      else if (ent && enp)
         op = OP_COUNT;
      else
         op = OP_HOLD;
   end
endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
   import cnt_pkg::*;
#(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         clr,
   input  logic         load,
   input  logic         ent,
   input  logic         enp,
   input  logic [W-1:0] din,
   output logic [W-1:0] q,
   output logic         carry
);
   localparam logic [W-1:0] MAXV = {W{1'b1}};

   if (W < 1) begin : g_bad_w
      $error("cnt_stage: W must be at least 1");
   end

   stage_op_e    op;
   logic [W-1:0] q_nxt;
   logic         primed = 1'b0;

   cnt_op_sel u_sel (
      .clr  (clr),
      .load (load),
      .ent  (ent),
      .enp  (enp),
      .op   (op)
   );

   always_comb begin
      unique case (op)
         OP_CLEAR: q_nxt = '0;
         OP_LOAD:  q_nxt = din;
         OP_COUNT: q_nxt = q + 1'b1;
         default:  q_nxt = q;
      endcase
   end

   always_ff @(posedge clk) begin
      q <= q_nxt;
      if (clr) primed <= 1'b1;
   end

   assign carry = ent && (q == MAXV);

   // R1
   clear_to_zero_chk: assert property (@(posedge clk) disable iff (!primed)
      clr |=> q == '0);
   // R2
   load_sync_chk: assert property (@(posedge clk) disable iff (!primed)
      (!clr && load) |=> q == $past(din));
   // R3
   count_step_chk: assert property (@(posedge clk) disable iff (!primed)
      (!clr && !load && ent && enp) |=> q == W'($past(q) + 1'b1));
   // R4
   hold_chk: assert property (@(posedge clk) disable iff (!primed)
      (!clr && !load && !(ent && enp)) |=> $stable(q));
endmodule

// File: rtl/casc_counter.sv
module casc_counter #(
   parameter int STAGE_W   = 4,
   parameter int STAGES    = 2,
   parameter bit LOOKAHEAD = 1'b0,
   localparam int TOTAL_W  = STAGE_W * STAGES
) (
   input  logic               clk,
   input  logic               clr,
   input  logic               en_p,
   input  logic               en_t,
   input  logic [TOTAL_W-1:0] preset,
   output logic [TOTAL_W-1:0] count,
   output logic               ripple_out
);
   localparam logic [STAGE_W-1:0] SMAX = {STAGE_W{1'b1}};

   if (STAGE_W < 1 || STAGES < 1) begin : g_bad_dims
      $error("casc_counter: STAGE_W and STAGES must be at least 1");
   end
   if (TOTAL_W > 32) begin : g_bad_total
      $error("casc_counter: total width limited to 32 bits");
   end

   logic [STAGES-1:0] stage_ent;
   logic [STAGES-1:0] stage_carry;
   logic              reload;
   logic              primed = 1'b0;

   assign reload     = &stage_carry;
   assign ripple_out = reload;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         assign stage_ent[i] = en_t;
      end else if (LOOKAHEAD) begin : g_look
         assign stage_ent[i] = en_t && (count[i*STAGE_W-1:0] == {(i*STAGE_W){1'b1}});
      end else begin : g_ripple
         assign stage_ent[i] = stage_carry[i-1];
      end

      cnt_stage #(.W(STAGE_W)) u_stage (
         .clk   (clk),
         .clr   (clr),
         .load  (reload),
         .ent   (stage_ent[i]),
         .enp   (en_p),
         .din   (preset[i*STAGE_W +: STAGE_W]),
         .q     (count[i*STAGE_W +: STAGE_W]),
         .carry (stage_carry[i])
      );
   end

   always_ff @(posedge clk) begin
      if (clr) primed <= 1'b1;
   end

   // R5
   ripple_full_chk: assert property (@(posedge clk) disable iff (!primed)
      ripple_out |-> (count == {TOTAL_W{1'b1}} && en_t));
   // R5
   ripple_gate_chk: assert property (@(posedge clk) disable iff (!primed)
      !en_t |-> !ripple_out);
   // R9
   reload_no_enp_chk: assert property (@(posedge clk) disable iff (!primed)
      (!clr && ripple_out && !en_p) |=> count == $past(preset));

   if (STAGES > 1) begin : g_casc_chk
      // R6
      upper_hold_chk: assert property (@(posedge clk) disable iff (!primed)
         (!clr && !ripple_out && count[STAGE_W-1:0] != SMAX)
         |=> $stable(count[TOTAL_W-1:STAGE_W]));
   end
endmodule

// File: tb/casc_counter_test.sv
`timescale 1ns/1ps
module casc_counter_test;
   logic       clk = 1'b0;
   logic       clr = 1'b1;
   logic       en_p = 1'b0;
   logic       en_t = 1'b0;
   logic [7:0] preset = 8'd0;
   logic [7:0] count;
   logic       ripple_out;

   int    n_chk = 0;
   int    n_bad = 0;
   int    ref_cnt = 0;
   string tag = "R1";
   bit    armed = 1'b0;
   bit    done = 1'b0;

   casc_counter uut (
      .clk        (clk),
      .clr        (clr),
      .en_p       (en_p),
      .en_t       (en_t),
      .preset     (preset),
      .count      (count),
      .ripple_out (ripple_out)
   );

   always #4 clk = ~clk;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
      end
   endtask

   // behavioural reference: clear, then reload at 255, then count, then hold
   always @(posedge clk) begin
      if (clr) begin
         ref_cnt = 0; tag = "R1";
      end else if (ref_cnt == 255 && en_t) begin
         ref_cnt = preset; tag = en_p ? "R2" : "R9";
      end else if (en_p && en_t) begin
         tag = (ref_cnt % 16 == 15) ? "R6" : "R3";
         ref_cnt = (ref_cnt + 1) % 256;
      end else begin
         tag = "R4";
      end
      armed = 1'b1;
   end

   always @(negedge clk) begin
      if (armed) begin
         check(count == ref_cnt[7:0], tag, count, ref_cnt);
         check(ripple_out == (ref_cnt == 255 && en_t), "R5", ripple_out,
               int'(ref_cnt == 255 && en_t));
      end
   end

   task automatic tick(input int n);
      repeat (n) begin
         @(posedge clk);
         #2;
      end
   endtask

   task automatic run_to_max();
      for (int k = 0; k < 300 && count != 8'd255; k++) tick(1);
   endtask

   initial begin
      int vals[20];
      int pulses;
      bit ok;
      tick(2);
      check(count == 8'd0, "R1", count, 0);

      // count up from zero with preset 246; preset wiggle mid-run has no effect (R2)
      clr = 1'b0; preset = 8'd246; en_p = 1'b1; en_t = 1'b1;
      tick(100);
      preset = 8'd17;
      tick(50);
      preset = 8'd246;
      tick(130);

      // R7: ten-state truncated loop
      for (int k = 0; k < 20; k++) begin
         vals[k] = count;
         tick(1);
      end
      ok = 1'b1;
      for (int k = 0; k < 10; k++) begin
         if (vals[k] < 246 || vals[k + 10] != vals[k]) ok = 1'b0;
         if (vals[k + 1] != ((vals[k] == 255) ? 246 : vals[k] + 1)) ok = 1'b0;
      end
      check(ok, "R7", vals[10], vals[0]);

      // R4: holds with either enable low
      en_p = 1'b0; tick(4);
      en_p = 1'b1; en_t = 1'b0; tick(4);
      en_t = 1'b1;

      // R9: reload at terminal count with en_p low
      run_to_max();
      en_p = 1'b0;
      tick(1);
      check(count == 8'd246, "R9", count, 246);
      en_p = 1'b1;

      // R5: en_t low at 255 hides carry and holds
      run_to_max();
      en_t = 1'b0;
      tick(3);
      check(ripple_out == 1'b0 && count == 8'd255, "R5", count, 255);

      // R1: clear coinciding with reload wins
      en_t = 1'b1;
      clr = 1'b1;
      tick(1);
      check(count == 8'd0, "R1", count, 0);

      // R8: full 256-cycle wrap
      preset = 8'd0;
      clr = 1'b0;
      pulses = 0;
      for (int k = 0; k < 256; k++) begin
         tick(1);
         if (ripple_out) pulses++;
      end
      check(count == 8'd0, "R8", count, 0);
      check(pulses == 1, "R8", pulses, 1);
      tick(1);
      check(count == 8'd1, "R3", count, 1);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule